// File: doc/BRIEF.md
# DMA Descriptor-Chaining Channel Sequencer

This block controls one DMA channel that works through a linked list of descriptors kept in memory. Each descriptor is four 32-bit words: a link word, a source address, a target address and a command word whose low bits give a byte count. The sequencer reads these words one at a time over a simple word-read port, loads them into its channel registers, and then runs a countdown that stands in for the byte-moving engine. When the count reaches zero it either follows the link to the next descriptor or halts, as bit 0 of the link word decides.

Software programs the channel through a small register port. A control write selects descriptor mode, which walks the chain from memory, or direct mode, in which software writes source, target and count itself and starts a single transfer. The source address is presented on the transfer port with its low bits cleared to match the alignment of its target: 8 bytes for an external device, 4 bytes for an internal one.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset all channel registers read as zero, the channel is idle (state code 0), and `stopped`, `mem_req` and `xfer_active` are low.
- R2: The link register (register 1) stores bits 31:4 and bit 0 of what is written or fetched; bits 3:1 always read as zero.
- R3: A start in descriptor mode issues four word reads at the link address with bits 3:0 cleared, then +4, +8, +12; each request holds its address until `mem_rvalid` and the next is issued only after that response.
- R4: The four fetched words load, in order, the link register, the source register, the target register and the count (bits 12:0 of the command word, register 4); the channel then enters transfer state (code 2) with no read request open.
- R5: In transfer state `xfer_active` is high while the count is nonzero, and the count drops by one on each cycle with `xfer_active` and `xfer_beat` both high.
- R6: In descriptor mode, when the count is zero and link bit 0 is 0, the channel fetches the next descriptor from the link address without any software action.
- R7: When the count is zero and link bit 0 is 1 (or the channel is in direct mode) the channel enters the halted state (code 3), drives `stopped` high, issues no further reads, and stays halted until software writes a start.
- R8: Writes to the source, target and count registers are ignored in descriptor mode and take effect in direct mode.
- R9: A start in direct mode goes straight to transfer state using the programmed count, issues no memory reads, and ends in the halted state.
- R10: `xfer_src` equals the source register with bits 2:0 cleared when control bit 2 (external target) is 1, and with bits 1:0 cleared when it is 0.
- R11: When a software write to the link register lands in the same cycle as the response to the first descriptor word, the fetched word is kept; a start written while the channel is fetching or transferring is ignored.
- R12: Control register (register 0): bit 0 start, bit 1 direct mode, bit 2 external target, bits 5:4 read back the state (0 idle, 1 fetch, 2 transfer, 3 halted). The mode bit changes only while the channel is idle or halted; the external bit changes on any control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 control, 1 link, 2 source, 3 target, 4 count |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mem_req | output | 1 | Descriptor word read request, held until response |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_rvalid | input | 1 | Read response valid for the open request |
| mem_rdata | input | 32 | Read response data |
| xfer_beat | input | 1 | Transfer engine accepts one unit this cycle |
| xfer_active | output | 1 | Transfer in progress with nonzero count |
| xfer_src | output | 32 | Aligned source address for the transfer engine |
| xfer_tgt | output | 32 | Target address for the transfer engine |
| stopped | output | 1 | Channel halted |

## Verification
Two pairs of events can coincide: a software write to the link register in the very cycle the first descriptor word returns, and a control write (start or mode change) while the channel is busy fetching or counting. The bench forces the first by having its memory responder raise the write strobe together with `mem_rvalid` for word 0, and the second by writing the control register as soon as `xfer_active` rises. A behavioural reference model updated on every edge predicts the link value, the state code and the mode bit, and all outputs are compared against it each cycle, alongside directed read-backs after each scenario.

// File: rtl/dma_chain_pkg.sv
`timescale 1ns/1ps
package dma_chain_pkg;
  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 4;
  localparam int IDX_W      = $clog2(DESC_WORDS);
  localparam int BASE_LSB   = IDX_W + 2;
  localparam int REG_AW     = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_XFER  = 2'd2,
    ST_HALT  = 2'd3
  } chan_state_e;

  localparam logic [REG_AW-1:0] RA_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] RA_LINK = 3'd1;
  localparam logic [REG_AW-1:0] RA_SRC  = 3'd2;
  localparam logic [REG_AW-1:0] RA_TGT  = 3'd3;
  localparam logic [REG_AW-1:0] RA_CNT  = 3'd4;

  localparam int CTL_RUN    = 0;
  localparam int CTL_DIRECT = 1;
  localparam int CTL_EXT    = 2;
  localparam int CTL_ST_LSB = 4;

  localparam logic [IDX_W-1:0] WI_LINK = IDX_W'(0);
  localparam logic [IDX_W-1:0] WI_SRC  = IDX_W'(1);
  localparam logic [IDX_W-1:0] WI_TGT  = IDX_W'(2);
  localparam logic [IDX_W-1:0] WI_CMD  = IDX_W'(DESC_WORDS - 1);

  localparam logic [WORD_W-1:0] LINK_KEEP = ~(WORD_W'(14));
endpackage

// File: rtl/dma_chain_regs.sv
`timescale 1ns/1ps
module dma_chain_regs
  import dma_chain_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sw_wr,
  input  logic [REG_AW-1:0]    sw_addr,
  input  logic [WORD_W-1:0]    sw_data,
  input  logic                 chan_quiet,
  input  logic                 fetch_vld,
  input  logic [IDX_W-1:0]     fetch_idx,
  input  logic [WORD_W-1:0]    fetch_data,
  output logic [WORD_W-1:0]    link_q,
  output logic [WORD_W-1:0]    src_q,
  output logic [WORD_W-1:0]    tgt_q,
  output logic                 direct_q,
  output logic                 ext_q
);
  logic ctrl_en, mode_en, link_en, src_en, tgt_en;
  logic fl_link, fl_src, fl_tgt;
  logic [WORD_W-1:0] link_d, src_d, tgt_d;

  always_comb begin
    fl_link = fetch_vld && (fetch_idx == WI_LINK);
    fl_src  = fetch_vld && (fetch_idx == WI_SRC);
    fl_tgt  = fetch_vld && (fetch_idx == WI_TGT);
    ctrl_en = sw_wr && (sw_addr == RA_CTRL);
    mode_en = ctrl_en && chan_quiet;
    // fetched word has priority over a coincident software write
    link_en = fl_link || (sw_wr && (sw_addr == RA_LINK));
    link_d  = (fl_link ? fetch_data : sw_data) & LINK_KEEP;
    src_en  = fl_src || (sw_wr && (sw_addr == RA_SRC) && direct_q);
    src_d   = fl_src ? fetch_data : sw_data;
    tgt_en  = fl_tgt || (sw_wr && (sw_addr == RA_TGT) && direct_q);
    tgt_d   = fl_tgt ? fetch_data : sw_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q   <= '0;
      src_q    <= '0;
      tgt_q    <= '0;
      direct_q <= 1'b0;
      ext_q    <= 1'b0;
    end else begin
      if (link_en) link_q   <= link_d;
      if (src_en)  src_q    <= src_d;
      if (tgt_en)  tgt_q    <= tgt_d;
      if (mode_en) direct_q <= sw_data[CTL_DIRECT];
      if (ctrl_en) ext_q    <= sw_data[CTL_EXT];
    end
  end
endmodule

// File: rtl/dma_chain_len.sv
`timescale 1ns/1ps
module dma_chain_len #(
  parameter int LEN_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_ld,
  input  logic [LEN_W-1:0] sw_val,
  input  logic             fetch_ld,
  input  logic [LEN_W-1:0] fetch_val,
  input  logic             dec,
  output logic [LEN_W-1:0] len_q,
  output logic             len_zero
);
  logic             len_en;
  logic [LEN_W-1:0] len_d;

  assign len_zero = (len_q == '0);

  always_comb begin
    len_en = fetch_ld || sw_ld || (dec && !len_zero);
    if (fetch_ld)   len_d = fetch_val;
    else if (sw_ld) len_d = sw_val;
    else            len_d = len_q - LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (len_en) len_q <= len_d;
  end
endmodule

// File: rtl/dma_chain_fsm.sv
`timescale 1ns/1ps
module dma_chain_fsm
  import dma_chain_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run_req,
  input  logic                     run_direct,
  input  logic [WORD_W-1:BASE_LSB] link_base,
  input  logic                     link_stop,
  input  logic                     direct_q,
  input  logic                     len_zero,
  input  logic                     mem_rvalid,
  input  logic                     xfer_beat,
  output chan_state_e              state_q,
  output logic                     mem_req,
  output logic [WORD_W-1:0]        mem_addr,
  output logic                     fetch_vld,
  output logic [IDX_W-1:0]         fetch_idx,
  output logic                     len_dec,
  output logic                     xfer_active
);
  chan_state_e               state_d;
  logic [WORD_W-1:BASE_LSB]  base_q;
  logic [IDX_W-1:0]          idx_q, idx_d;
  logic                      base_en, idx_en;

  always_comb begin
    state_d = state_q;
    base_en = 1'b0;
    idx_en  = 1'b0;
    idx_d   = idx_q;
    case (state_q)
      ST_IDLE, ST_HALT: begin
        if (run_req) begin
          if (run_direct) begin
            state_d = ST_XFER;
          end else begin
            state_d = ST_FETCH;
            base_en = 1'b1;
            idx_en  = 1'b1;
            idx_d   = '0;
          end
        end
      end
      ST_FETCH: begin
        if (mem_rvalid) begin
          idx_en = 1'b1;
          idx_d  = idx_q + IDX_W'(1);
          if (idx_q == WI_CMD) state_d = ST_XFER;
        end
      end
      default: begin
        if (len_zero) begin
          if (direct_q || link_stop) begin
            state_d = ST_HALT;
          end else begin
            state_d = ST_FETCH;
            base_en = 1'b1;
            idx_en  = 1'b1;
            idx_d   = '0;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (base_en) base_q <= link_base;
      if (idx_en)  idx_q  <= idx_d;
    end
  end

  assign mem_req     = (state_q == ST_FETCH);
  assign mem_addr    = {base_q, idx_q, 2'b00};
  assign fetch_vld   = mem_req && mem_rvalid;
  assign fetch_idx   = idx_q;
  assign xfer_active = (state_q == ST_XFER) && !len_zero;
  assign len_dec     = xfer_active && xfer_beat;
endmodule

// File: rtl/dma_chain_seq.sv
`timescale 1ns/1ps
module dma_chain_seq
  import dma_chain_pkg::*;
#(
  parameter int LEN_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              mem_req,
  output logic [WORD_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              xfer_beat,
  output logic              xfer_active,
  output logic [WORD_W-1:0] xfer_src,
  output logic [WORD_W-1:0] xfer_tgt,
  output logic              stopped
);
  logic rst_meta, rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_core_n <= rst_meta;
    end
  end

  chan_state_e       state;
  logic              quiet, run_req, cnt_wr, fetch_vld, len_dec, len_zero;
  logic              direct_q, ext_q;
  logic [IDX_W-1:0]  fetch_idx;
  logic [WORD_W-1:0] link_q, src_q, tgt_q;
  logic [LEN_W-1:0]  len_q;

  assign quiet   = (state == ST_IDLE) || (state == ST_HALT);
  assign run_req = reg_wr_en && (reg_addr == RA_CTRL) && reg_wdata[CTL_RUN] && quiet;
  assign cnt_wr  = reg_wr_en && (reg_addr == RA_CNT) && direct_q;

  dma_chain_regs u_regs (
    .clk(clk), .rst_n(rst_core_n),
    .sw_wr(reg_wr_en), .sw_addr(reg_addr), .sw_data(reg_wdata),
    .chan_quiet(quiet),
    .fetch_vld(fetch_vld), .fetch_idx(fetch_idx), .fetch_data(mem_rdata),
    .link_q(link_q), .src_q(src_q), .tgt_q(tgt_q),
    .direct_q(direct_q), .ext_q(ext_q)
  );

  dma_chain_len #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst_n(rst_core_n),
    .sw_ld(cnt_wr), .sw_val(reg_wdata[LEN_W-1:0]),
    .fetch_ld(fetch_vld && (fetch_idx == WI_CMD)), .fetch_val(mem_rdata[LEN_W-1:0]),
    .dec(len_dec), .len_q(len_q), .len_zero(len_zero)
  );

  dma_chain_fsm u_fsm (
    .clk(clk), .rst_n(rst_core_n),
    .run_req(run_req), .run_direct(reg_wdata[CTL_DIRECT]),
    .link_base(link_q[WORD_W-1:BASE_LSB]), .link_stop(link_q[0]),
    .direct_q(direct_q), .len_zero(len_zero),
    .mem_rvalid(mem_rvalid), .xfer_beat(xfer_beat),
    .state_q(state), .mem_req(mem_req), .mem_addr(mem_addr),
    .fetch_vld(fetch_vld), .fetch_idx(fetch_idx),
    .len_dec(len_dec), .xfer_active(xfer_active)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL: begin
        reg_rdata[CTL_ST_LSB +: 2] = state;
        reg_rdata[CTL_EXT]         = ext_q;
        reg_rdata[CTL_DIRECT]      = direct_q;
      end
      RA_LINK: reg_rdata = link_q;
      RA_SRC:  reg_rdata = src_q;
      RA_TGT:  reg_rdata = tgt_q;
      RA_CNT:  reg_rdata[LEN_W-1:0] = len_q;
      default: reg_rdata = '0;
    endcase
  end

  // external targets need 8-byte alignment, internal ones 4-byte
  assign xfer_src = {src_q[WORD_W-1:3], ext_q ? 1'b0 : src_q[2], 2'b00};
  assign xfer_tgt = tgt_q;
  assign stopped  = (state == ST_HALT);
endmodule

// File: rtl/dma_chain_seq_chk.sv
`timescale 1ns/1ps
module dma_chain_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr_en,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_rvalid,
  input logic        xfer_active,
  input logic        stopped
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr)); // R3

  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_rvalid && (mem_addr[3:2] != 2'b11) |=> mem_req && (mem_addr == $past(mem_addr) + 32'd4)); // R3

  AST_LAST_WORD_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_rvalid && (mem_addr[3:2] == 2'b11) |=> !mem_req); // R4

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !xfer_active); // R4

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    stopped && !(reg_wr_en && (reg_addr == 3'd0) && reg_wdata[0]) |=> stopped); // R7

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> !mem_req && !xfer_active); // R7

  AST_LINK_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd1) |-> (reg_rdata[3:1] == 3'b000)); // R2
endmodule

bind dma_chain_seq dma_chain_seq_chk chk_i (.*);

// File: tb/dma_chain_seq_tb_top.sv
`timescale 1ns/1ps
module dma_chain_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        xfer_beat = 1'b0;
  logic        xfer_active, stopped;
  logic [31:0] xfer_src, xfer_tgt;

  always #2 clk = ~clk;

  dma_chain_seq dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .xfer_beat(xfer_beat), .xfer_active(xfer_active), .xfer_src(xfer_src),
    .xfer_tgt(xfer_tgt), .stopped(stopped)
  );

  int    n_chk = 0, n_fail = 0, cyc = 0;
  int    fetch_cnt = 0, beat_cnt = 0, lat = 0, lat_cnt = 0;
  bit    beat_on = 0, collide = 0, clr_wr = 0;
  string phase = "R1";
  logic [31:0] mem [logic [31:0]];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // ---------------- reference model ----------------
  logic [1:0]  m_st;
  logic [31:0] m_link, m_src, m_tgt, m_base;
  logic [12:0] m_len;
  logic [1:0]  m_idx;
  bit          m_dir, m_ext;
  int          m_rcnt;

  function automatic void m_reset();
    m_st = 0; m_link = 0; m_src = 0; m_tgt = 0; m_base = 0;
    m_len = 0; m_idx = 0; m_dir = 0; m_ext = 0;
  endfunction

  function automatic void m_step();
    bit          quiet = (m_st == 0) || (m_st == 3);
    bit          od = m_dir;
    logic [31:0] ol = m_link;
    logic [12:0] olen = m_len;
    bit          cntw = reg_wr_en && reg_addr == 4 && od;
    logic [1:0]  ost = m_st;
    if (reg_wr_en) begin
      case (reg_addr)
        3'd0: begin m_ext = reg_wdata[2]; if (quiet) m_dir = reg_wdata[1]; end
        3'd1: m_link = reg_wdata & 32'hFFFF_FFF1;
        3'd2: if (od) m_src = reg_wdata;
        3'd3: if (od) m_tgt = reg_wdata;
        3'd4: if (od) m_len = reg_wdata[12:0];
        default: ;
      endcase
    end
    case (ost)
      2'd0, 2'd3: if (reg_wr_en && reg_addr == 0 && reg_wdata[0]) begin
        if (reg_wdata[1]) m_st = 2;
        else begin m_st = 1; m_base = ol & ~32'hF; m_idx = 0; end
      end
      2'd1: if (mem_rvalid) begin
        case (m_idx)
          2'd0: m_link = mem_rdata & 32'hFFFF_FFF1;
          2'd1: m_src = mem_rdata;
          2'd2: m_tgt = mem_rdata;
          default: begin m_len = mem_rdata[12:0]; m_st = 2; end
        endcase
        m_idx = m_idx + 1;
      end
      default: begin
        if (olen == 0) begin
          if (od || ol[0]) m_st = 3;
          else begin m_st = 1; m_base = ol & ~32'hF; m_idx = 0; end
        end else if (xfer_beat && !cntw) m_len = olen - 1;
      end
    endcase
  endfunction

  function automatic logic [31:0] m_read(logic [2:0] a);
    case (a)
      3'd0: return {26'd0, m_st, 1'b0, m_ext, m_dir, 1'b0};
      3'd1: return m_link;
      3'd2: return m_src;
      3'd3: return m_tgt;
      3'd4: return {19'd0, m_len};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin m_rcnt = 0; m_reset(); end
    else if (m_rcnt < 2) m_rcnt++;
    else m_step();
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (cyc > 0) begin
      chk(phase, "mem_req", {31'd0, mem_req}, {31'd0, m_st == 2'd1});
      if (m_st == 2'd1) chk(phase, "mem_addr", mem_addr, {m_base[31:4], m_idx, 2'b00});
      chk(phase, "xfer_active", {31'd0, xfer_active}, {31'd0, (m_st == 2'd2) && (m_len != 0)});
      chk(phase, "stopped", {31'd0, stopped}, {31'd0, m_st == 2'd3});
      chk(phase, "xfer_src", xfer_src, m_src & (m_ext ? ~32'd7 : ~32'd3));
      chk(phase, "xfer_tgt", xfer_tgt, m_tgt);
      chk(phase, "reg_rdata", reg_rdata, m_read(reg_addr));
      if (mem_req && mem_rvalid) fetch_cnt++;
      if (xfer_active && xfer_beat) beat_cnt++;
    end
  end

  // memory responder and beat source, driven after the edge
  always @(posedge clk) begin
    #1;
    if (clr_wr) begin reg_wr_en = 0; clr_wr = 0; end
    xfer_beat = beat_on && (cyc % 3 != 1);
    if (mem_rvalid) begin
      mem_rvalid = 0; lat_cnt = 0;
    end else if (mem_req) begin
      if (lat_cnt >= lat) begin
        mem_rvalid = 1;
        mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'd0;
        if (collide && mem_addr[3:2] == 2'b00) begin
          // software link write lands with the word-0 response (R11)
          reg_wr_en = 1; reg_addr = 3'd1; reg_wdata = 32'hDEAD_BEE0;
          collide = 0; clr_wr = 1;
        end
      end else lat_cnt++;
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(posedge clk); #1;
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr_en = 0;
  endtask

  task automatic rd(string req, logic [2:0] a, logic [31:0] exp);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    chk(req, "read", reg_rdata, exp);
  endtask

  task automatic wait_stop();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (stopped) break;
    end
  endtask

  initial begin
    int f0, b0;
    mem[32'h100] = 32'h0000_0200; mem[32'h104] = 32'h0000_1003;
    mem[32'h108] = 32'h0000_8000; mem[32'h10C] = 32'h0000_0003;
    mem[32'h200] = 32'h0000_0301; mem[32'h204] = 32'h0000_5557;
    mem[32'h208] = 32'h0000_9000; mem[32'h20C] = 32'hFFFF_E002;
    mem[32'h400] = 32'h0000_0501; mem[32'h404] = 32'h0000_0040;
    mem[32'h408] = 32'h0000_0044; mem[32'h40C] = 32'h0000_0006;

    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (5) @(posedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) rd("R1", 3'(a), 32'd0);
    chk("R1", "stopped", {31'd0, stopped}, 32'd0);
    chk("R1", "mem_req", {31'd0, mem_req}, 32'd0);
    chk("R1", "xfer_active", {31'd0, xfer_active}, 32'd0);

    // R2 reserved link bits
    phase = "R2";
    wr(3'd1, 32'hFFFF_FFFF);
    rd("R2", 3'd1, 32'hFFFF_FFF1);

    // R8 writes ignored in descriptor mode
    phase = "R8";
    wr(3'd2, 32'h1234); wr(3'd3, 32'h5678); wr(3'd4, 32'd5);
    rd("R8", 3'd2, 32'd0); rd("R8", 3'd3, 32'd0); rd("R8", 3'd4, 32'd0);

    // R3..R7 two-descriptor chain, external source
    phase = "R6";
    wr(3'd0, 32'h4);
    wr(3'd1, 32'h100);
    lat = 1; beat_on = 1; f0 = fetch_cnt;
    wr(3'd0, 32'h5);
    wait_stop();
    chk("R3", "fetch count", 32'(fetch_cnt - f0), 32'd8);
    rd("R6", 3'd1, 32'h301);
    rd("R4", 3'd2, 32'h5557);
    chk("R10", "xfer_src ext", xfer_src, 32'h5550);
    chk("R4", "xfer_tgt", xfer_tgt, 32'h9000);
    rd("R5", 3'd4, 32'd0);
    rd("R7", 3'd0, 32'h34);
    f0 = fetch_cnt;
    repeat (10) @(negedge clk);
    chk("R7", "stopped held", {31'd0, stopped}, 32'd1);
    chk("R7", "no fetch while halted", 32'(fetch_cnt - f0), 32'd0);

    // R11 / R12 collisions
    phase = "R11";
    wr(3'd1, 32'h400);
    lat = 2; collide = 1;
    wr(3'd0, 32'h1);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (xfer_active) break;
    end
    wr(3'd0, 32'h3);
    rd("R12", 3'd0, 32'h20);
    wait_stop();
    rd("R11", 3'd1, 32'h501);
    chk("R10", "xfer_src int", xfer_src, 32'h40);
    rd("R12", 3'd0, 32'h30);

    // R9 direct mode
    phase = "R9";
    f0 = fetch_cnt;
    wr(3'd0, 32'h2);
    wr(3'd2, 32'h7777); wr(3'd3, 32'hABCD); wr(3'd4, 32'd4);
    rd("R8", 3'd2, 32'h7777);
    rd("R8", 3'd4, 32'd4);
    chk("R10", "xfer_src int", xfer_src, 32'h7774);
    b0 = beat_cnt;
    wr(3'd0, 32'h3);
    @(negedge clk);
    chk("R9", "direct start active", {31'd0, xfer_active}, 32'd1);
    chk("R9", "direct start no read", {31'd0, mem_req}, 32'd0);
    wait_stop();
    chk("R5", "beats consumed", 32'(beat_cnt - b0), 32'd4);
    chk("R9", "no fetch", 32'(fetch_cnt - f0), 32'd0);
    rd("R9", 3'd0, 32'h32);
    wr(3'd0, 32'h6);
    @(negedge clk);
    chk("R10", "xfer_src ext", xfer_src, 32'h7770);
    wr(3'd0, 32'h7);
    repeat (3) @(negedge clk);
    chk("R9", "zero count halts", {31'd0, stopped}, 32'd1);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule